// File: doc/BRIEF.md
# Host Interrupt Status Aggregator

The block gathers single-cycle event pulses from up to `NUM_SRC` internal sources into a sticky status vector. It drives one level-sensitive interrupt line toward a host processor. Each status bit stays set until the host clears it. A per-bit mask decides which pending bits may raise the line. The line itself has a global enable and a selectable active level.

The host reaches the block through a small word-addressed register port. The port has an address, a write strobe with write data, and a read strobe. Read data is registered, so it appears the cycle after the read strobe and holds until the next read. The mask can be written whole, or changed one bit at a time through write-only set and clear aliases. The status vector can be read in two ways: a peek view that leaves it alone, and a take view that empties it. Individual status bits can also be retired by writing ones to an acknowledge register. The register map, by word address, is:

- 0: mask, read/write
- 1: mask-set alias
- 2: mask-clear alias
- 3: status peek view
- 4: status take view
- 5: acknowledge
- 6: line configuration
- 7: unused

The suggested source wiring is:

| Bit | Source |
|-----|--------|
| 0 | receive buffer A ready |
| 1 | transmit data done |
| 2 | transmit transfer done |
| 3 | receive buffer B ready |
| 4 | receive transfer done |
| 5, 6 | two mailbox events |
| 7 | wake request |
| 8, 9 | two trace events |
| 10 | command done |
| 14 | init done |
| 16 | coexistence sensing on |
| 17 | coexistence sensing off |

Top module: `irq_agg`

## Requirements
- R1: After reset the mask reads 0x000001 (only source 0 blocked), the status reads 0, the configuration word reads 0 and `hostIrq` is 0.
- R2: A one-cycle pulse on `srcPulse[i]` sets status bit i at the next clock edge. The bit then stays set, with no further pulses, until a take read or an acknowledge clears it.
- R3: A write to address 0 loads the low `NUM_SRC` bits of the write data into the mask. A read of address 0 returns the mask, with zeros above bit `NUM_SRC-1`. Read data appears on `regRdData` the cycle after `regRdEn` and holds until the next read.
- R4: Writing to address 1 sets every mask bit whose write-data bit is 1 and leaves the other mask bits unchanged. Reading address 1 returns 0.
- R5: Writing to address 2 clears every mask bit whose write-data bit is 1 and leaves the other mask bits unchanged. Reading address 2 returns 0.
- R6: Reading address 3 returns the status vector and leaves it unchanged.
- R7: Reading address 4 returns the status vector as it stood before the read. All status bits are cleared at that same edge.
- R8: Writing to address 5 clears every status bit whose write-data bit is 1. Bits written 0 are unaffected. Reading address 5 returns 0.
- R9: If a source pulse arrives in the same cycle as a take read or an acknowledge that would clear the same bit, the bit ends up set.
- R10: Address 6 holds the line configuration: bit 0 is the enable and bit 1 is the active-low select. While the enable is 0, `hostIrq` sits at its inactive level, which is 0 when bit 1 is 0 and 1 when bit 1 is 1. While the enable is 1, `hostIrq` is active exactly when a status bit is set whose mask bit is 0. The output is registered and follows the status and mask registers by one cycle.
- R11: With configuration bit 1 set, the active level of `hostIrq` is 0 and the inactive level is 1. With bit 1 clear, active is 1 and inactive is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| srcPulse | input | NUM_SRC | One-cycle event pulses, one per source |
| regAddr | input | 3 | Register word address |
| regWrEn | input | 1 | Write strobe |
| regWrData | input | DATA_W | Write data |
| regRdEn | input | 1 | Read strobe |
| regRdData | output | DATA_W | Registered read data, valid the cycle after the read strobe |
| hostIrq | output | 1 | Host interrupt line, polarity per configuration |

## Verification
The two functions that can meet in one cycle are setting a status bit from a source pulse and clearing that bit, either through a take read or through an acknowledge write. The bench provokes this on purpose in two ways:

- A pulse on bit 5 is issued in the very cycle of a take read.
- A pulse on bit 6 is issued together with an acknowledge of bit 6.

In each case a following peek read must show the bit still set, while the take read itself returns only the older contents. A long random phase then scatters pulses against every register access. A behavioural model compares the read data and the interrupt line on every clock, so any cycle where clearing beats a new event is caught.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  localparam int REG_ADDR_W = 3;

  typedef enum logic [REG_ADDR_W-1:0] {
    ADR_MASK = 3'd0,
    ADR_MSET = 3'd1,
    ADR_MCLR = 3'd2,
    ADR_PEEK = 3'd3,
    ADR_TAKE = 3'd4,
    ADR_ACK  = 3'd5,
    ADR_CFG  = 3'd6,
    ADR_VOID = 3'd7
  } regAddr_e;

  typedef enum logic [1:0] {
    SEL_ZERO,
    SEL_MASK,
    SEL_STAT,
    SEL_CFG
  } rdSel_e;

  typedef struct packed {
    logic   wrMask;
    logic   setMask;
    logic   clrMask;
    logic   ackStat;
    logic   takeStat;
    logic   wrCfg;
    logic   rdLoad;
    rdSel_e rdSel;
  } strobe_t;

endpackage

// File: rtl/irq_agg_ctrl.sv
module irq_agg_ctrl
  import irq_agg_pkg::*;
(
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic                  regWrEn,
  input  logic                  regRdEn,
  output strobe_t               strobe
);

  regAddr_e addrDec;
  assign addrDec = regAddr_e'(regAddr);

  always_comb begin
    strobe          = '0;
    strobe.rdSel    = SEL_ZERO;
    strobe.rdLoad   = regRdEn;
    strobe.wrMask   = regWrEn && (addrDec == ADR_MASK);
    strobe.setMask  = regWrEn && (addrDec == ADR_MSET);
    strobe.clrMask  = regWrEn && (addrDec == ADR_MCLR);
    strobe.ackStat  = regWrEn && (addrDec == ADR_ACK);
    strobe.wrCfg    = regWrEn && (addrDec == ADR_CFG);
    strobe.takeStat = regRdEn && (addrDec == ADR_TAKE);
    case (addrDec)
      ADR_MASK: strobe.rdSel = SEL_MASK;
      ADR_PEEK: strobe.rdSel = SEL_STAT;
      ADR_TAKE: strobe.rdSel = SEL_STAT;
      ADR_CFG:  strobe.rdSel = SEL_CFG;
      default:  strobe.rdSel = SEL_ZERO;
    endcase
  end

endmodule

// File: rtl/irq_agg_dp.sv
module irq_agg_dp
  import irq_agg_pkg::*;
#(
  parameter int                 NUM_SRC  = 22,
  parameter int                 DATA_W   = 32,
  parameter logic [NUM_SRC-1:0] MASK_RST = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  strobe_t            strobe,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [NUM_SRC-1:0] srcPulse,
  output logic [DATA_W-1:0]  rdData,
  output logic               irqOut,
  output logic [NUM_SRC-1:0] statusVec,
  output logic [NUM_SRC-1:0] maskVec,
  output logic               cfgEn,
  output logic               cfgLow
);

  localparam int CFG_EN_BIT  = 0;
  localparam int CFG_LOW_BIT = 1;

  logic [NUM_SRC-1:0] wrBits;
  logic [NUM_SRC-1:0] clrBits;
  logic [DATA_W-1:0]  rdNext;
  logic               pending;

  assign wrBits  = wrData[NUM_SRC-1:0];
  assign clrBits = strobe.takeStat ? '1 : (strobe.ackStat ? wrBits : '0);

  // Sticky status cells: a new event outranks any clear in the same cycle.
  for (genvar i = 0; i < NUM_SRC; i++) begin : gStat
    always_ff @(posedge clk) begin
      if (rst)              statusVec[i] <= 1'b0;
      else if (srcPulse[i]) statusVec[i] <= 1'b1;
      else if (clrBits[i])  statusVec[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                 maskVec <= MASK_RST;
    else if (strobe.wrMask)  maskVec <= wrBits;
    else if (strobe.setMask) maskVec <= maskVec | wrBits;
    else if (strobe.clrMask) maskVec <= maskVec & ~wrBits;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfgEn  <= 1'b0;
      cfgLow <= 1'b0;
    end else if (strobe.wrCfg) begin
      cfgEn  <= wrData[CFG_EN_BIT];
      cfgLow <= wrData[CFG_LOW_BIT];
    end
  end

  always_comb begin
    rdNext = '0;
    case (strobe.rdSel)
      SEL_MASK: rdNext[NUM_SRC-1:0] = maskVec;
      SEL_STAT: rdNext[NUM_SRC-1:0] = statusVec;
      SEL_CFG: begin
        rdNext[CFG_EN_BIT]  = cfgEn;
        rdNext[CFG_LOW_BIT] = cfgLow;
      end
      default: rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)                rdData <= '0;
    else if (strobe.rdLoad) rdData <= rdNext;
  end

  assign pending = |(statusVec & ~maskVec);

  always_ff @(posedge clk) begin
    if (rst) irqOut <= 1'b0;
    else     irqOut <= cfgEn ? (pending ^ cfgLow) : cfgLow;
  end

endmodule

// File: rtl/irq_agg.sv
module irq_agg
  import irq_agg_pkg::*;
#(
  parameter int NUM_SRC = 22,
  parameter int DATA_W  = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_SRC-1:0]    srcPulse,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic                  regWrEn,
  input  logic [DATA_W-1:0]     regWrData,
  input  logic                  regRdEn,
  output logic [DATA_W-1:0]     regRdData,
  output logic                  hostIrq
);

  strobe_t            strobe;
  logic [NUM_SRC-1:0] statusVec;
  logic [NUM_SRC-1:0] maskVec;
  logic               cfgEn;
  logic               cfgLow;

  irq_agg_ctrl uCtrl (
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .regRdEn (regRdEn),
    .strobe  (strobe)
  );

  irq_agg_dp #(
    .NUM_SRC  (NUM_SRC),
    .DATA_W   (DATA_W),
    .MASK_RST (1)
  ) uDp (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .wrData    (regWrData),
    .srcPulse  (srcPulse),
    .rdData    (regRdData),
    .irqOut    (hostIrq),
    .statusVec (statusVec),
    .maskVec   (maskVec),
    .cfgEn     (cfgEn),
    .cfgLow    (cfgLow)
  );

endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk
  import irq_agg_pkg::*;
#(
  parameter int NUM_SRC = 22,
  parameter int DATA_W  = 32
) (
  input logic                  clk,
  input logic                  rst,
  input logic [NUM_SRC-1:0]    srcPulse,
  input logic [REG_ADDR_W-1:0] regAddr,
  input logic                  regWrEn,
  input logic [DATA_W-1:0]     regWrData,
  input logic                  regRdEn,
  input logic                  hostIrq,
  input logic [NUM_SRC-1:0]    statusVec,
  input logic [NUM_SRC-1:0]    maskVec,
  input logic                  cfgEn,
  input logic                  cfgLow
);

  AST_PULSE_SETS: assert property (@(posedge clk) disable iff (rst)
    (srcPulse != '0) |=> ((statusVec & $past(srcPulse)) == $past(srcPulse))); // R2

  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (rst)
    (regRdEn && regAddr == ADR_TAKE && srcPulse != '0) |=> (statusVec == $past(srcPulse))); // R9

  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (rst)
    (regWrEn && regAddr == ADR_MASK) |=> (maskVec == $past(regWrData[NUM_SRC-1:0]))); // R3

  AST_MASK_SET: assert property (@(posedge clk) disable iff (rst)
    (regWrEn && regAddr == ADR_MSET) |=> (maskVec == ($past(maskVec) | $past(regWrData[NUM_SRC-1:0])))); // R4

  AST_MASK_CLR: assert property (@(posedge clk) disable iff (rst)
    (regWrEn && regAddr == ADR_MCLR) |=> (maskVec == ($past(maskVec) & ~$past(regWrData[NUM_SRC-1:0])))); // R5

  AST_PEEK_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (regRdEn && regAddr == ADR_PEEK && !(regWrEn && regAddr == ADR_ACK))
      |=> (statusVec == ($past(statusVec) | $past(srcPulse)))); // R6

  AST_TAKE_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    (regRdEn && regAddr == ADR_TAKE && srcPulse == '0) |=> (statusVec == '0)); // R7

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (regWrEn && regAddr == ADR_ACK && srcPulse == '0)
      |=> ((statusVec & $past(regWrData[NUM_SRC-1:0])) == '0)); // R8

  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (!cfgEn) |=> (hostIrq == $past(cfgLow))); // R10

  AST_ACTIVE_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (cfgEn && ((statusVec & ~maskVec) != '0)) |=> (hostIrq == !$past(cfgLow))); // R11

endmodule

bind irq_agg irq_agg_chk #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) uChk (
  .clk       (clk),
  .rst       (rst),
  .srcPulse  (srcPulse),
  .regAddr   (regAddr),
  .regWrEn   (regWrEn),
  .regWrData (regWrData),
  .regRdEn   (regRdEn),
  .hostIrq   (hostIrq),
  .statusVec (statusVec),
  .maskVec   (maskVec),
  .cfgEn     (cfgEn),
  .cfgLow    (cfgLow)
);

// File: tb/sim_irq_agg.sv
`timescale 1ns/1ps
module sim_irq_agg;

  localparam int N = 22;
  localparam int W = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  srcPulse = '0;
  logic [2:0]    regAddr = '0;
  logic          regWrEn = 1'b0;
  logic [W-1:0]  regWrData = '0;
  logic          regRdEn = 1'b0;
  logic [W-1:0]  regRdData;
  logic          hostIrq;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  irq_agg #(.NUM_SRC(N), .DATA_W(W)) u0 (
    .clk(clk), .rst(rst), .srcPulse(srcPulse), .regAddr(regAddr),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdEn(regRdEn),
    .regRdData(regRdData), .hostIrq(hostIrq)
  );

  // Behavioural reference model
  logic [N-1:0] mMask, mStat, mClr, mWr;
  logic         mEn, mLow, mIrq;
  logic [W-1:0] mRd;

  always @(posedge clk) begin
    if (rst) begin
      mMask = 22'h1; mStat = '0; mEn = 0; mLow = 0; mIrq = 0; mRd = '0;
    end else begin
      mWr  = regWrData[N-1:0];
      mIrq = mEn ? ((|(mStat & ~mMask)) ^ mLow) : mLow;
      if (regRdEn) begin
        case (regAddr)
          3'd0:      mRd = W'(mMask);
          3'd3, 3'd4: mRd = W'(mStat);
          3'd6:      mRd = W'({mLow, mEn});
          default:   mRd = '0;
        endcase
      end
      mClr = '0;
      if (regRdEn && regAddr == 3'd4) mClr = '1;
      else if (regWrEn && regAddr == 3'd5) mClr = mWr;
      mStat = (mStat & ~mClr) | srcPulse;
      if (regWrEn) begin
        case (regAddr)
          3'd0: mMask = mWr;
          3'd1: mMask = mMask | mWr;
          3'd2: mMask = mMask & ~mWr;
          3'd6: begin mEn = regWrData[0]; mLow = regWrData[1]; end
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      chk("R10 hostIrq vs model", W'(hostIrq), W'(mIrq));
      chk("R3 regRdData vs model", regRdData, mRd);
    end
  end

  task automatic op(input bit w, input bit r, input logic [2:0] a,
                    input logic [W-1:0] d, input logic [N-1:0] s,
                    output logic [W-1:0] q);
    @(negedge clk);
    regWrEn = w; regRdEn = r; regAddr = a; regWrData = d; srcPulse = s;
    @(negedge clk);
    regWrEn = 0; regRdEn = 0; srcPulse = '0;
    q = regRdData;
  endtask

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    logic [W-1:0] q;
    op(1, 0, a, d, '0, q);
  endtask

  task automatic rd(input logic [2:0] a, output logic [W-1:0] q);
    op(0, 1, a, '0, '0, q);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #4_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [W-1:0] q;
    repeat (3) @(negedge clk);
    rst = 0;
    idle(1);
    chk("R1 reset irq", W'(hostIrq), 0);
    rd(3'd0, q); chk("R1 reset mask", q, 32'h1);
    rd(3'd3, q); chk("R1 reset status", q, 0);
    rd(3'd6, q); chk("R1 reset cfg", q, 0);

    op(0, 0, 3'd0, 0, 22'h8, q);
    idle(3);
    rd(3'd3, q); chk("R2 sticky bit3", q, 32'h8);
    rd(3'd3, q); chk("R6 peek unchanged", q, 32'h8);
    chk("R10 disabled idle low", W'(hostIrq), 0);

    wr(3'd6, 32'h1); idle(2);
    chk("R10 enabled pending", W'(hostIrq), 1);
    wr(3'd1, 32'h8); idle(2);
    rd(3'd0, q); chk("R4 mask set", q, 32'h9);
    chk("R10 masked quiet", W'(hostIrq), 0);
    rd(3'd1, q); chk("R4 alias reads zero", q, 0);
    wr(3'd2, 32'h1);
    rd(3'd0, q); chk("R5 mask clear", q, 32'h8);
    rd(3'd2, q); chk("R5 alias reads zero", q, 0);
    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd0, q); chk("R3 mask load width", q, 32'h3F_FFFF);
    wr(3'd0, 32'h0);
    rd(3'd0, q); chk("R3 mask load zero", q, 0);

    op(0, 0, 3'd0, 0, 22'h105, q);
    wr(3'd5, 32'h4);
    rd(3'd3, q); chk("R8 ack one bit", q, 32'h109);
    wr(3'd5, 32'h0);
    rd(3'd3, q); chk("R8 ack zero no effect", q, 32'h109);
    rd(3'd5, q); chk("R8 ack reads zero", q, 0);

    rd(3'd4, q); chk("R7 take returns", q, 32'h109);
    rd(3'd3, q); chk("R7 take cleared", q, 0);

    op(0, 0, 3'd0, 0, 22'h1, q);
    op(0, 1, 3'd4, 0, 22'h20, q); chk("R9 take returns older", q, 32'h1);
    rd(3'd3, q); chk("R9 pulse beats take", q, 32'h20);
    op(1, 0, 3'd5, 32'h60, 22'h40, q);
    rd(3'd3, q); chk("R9 pulse beats ack", q, 32'h40);

    wr(3'd6, 32'h3); idle(2);
    chk("R11 active low asserted", W'(hostIrq), 0);
    wr(3'd5, 32'h3F_FFFF); idle(2);
    chk("R11 active low idle", W'(hostIrq), 1);
    wr(3'd6, 32'h2); op(0, 0, 3'd0, 0, 22'h2, q); idle(2);
    chk("R10 disabled low-idle", W'(hostIrq), 1);
    rd(3'd6, q); chk("R10 cfg readback", q, 32'h2);

    for (int i = 0; i < 3000; i++) begin
      logic [W-1:0] d;
      logic [N-1:0] s;
      d = $urandom;
      s = (($urandom % 4) == 0) ? N'(1 << ($urandom % N)) : '0;
      op(($urandom % 2) == 1, ($urandom % 2) == 1, 3'($urandom), d, s, q);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule